// File: doc/BRIEF.md
# Parity-Guarded Read-Only Store

This block is a read-only word store that keeps one even-parity bit for every byte of every word and checks those bits on each read. A 2-bit read mode selects how a read is handled. Reads can be normal and checked, checked but with the interrupt muted, unchecked, or turned into a view of the stored parity bits. A force control inverts the parity bits handed to the checker, so software can prove that the error path works. Both controls sit behind a lock input that freezes them.

Reads use a valid/ready request channel carrying an address and a valid/ready response channel carrying the word. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears after that edge and stays put until the consumer takes it with `rsp_ready`. While an untaken response is held, `req_ready` is low, so no second request can overwrite it. With `rsp_ready` held high, one read completes every cycle with one cycle of latency.

The contents are generated from the address at elaboration, with no external file. Let `h = (a * 0x9E3779B1) mod 2^32` for address `a`. Word `a` is `h XOR 0xC3A50F96`. The stored parity bit for byte i (bits 8i+7..8i) is the XOR of that byte's bits.

Top module: `rom_parity_guard`

## Requirements
- R1: After reset the read mode and force control are 0, `err_flag`, `err_irq` and `rsp_valid` are 0, and `req_ready` is 1. A read in this state returns the stored word and flags no error.
- R2: A request taken at edge N gives `rsp_valid`=1 and `rsp_data` = the word at `req_addr` right after edge N. This holds for every address, from 0 to the last one.
- R3: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_data` holds its value. A new request is taken in the same cycle that `rsp_ready` returns to 1.
- R4: Mode 0 (binary 00) checks parity. An erroneous read sets `err_flag` and raises `err_irq` alongside that read's response.
- R5: Mode 1 (binary 01) returns the data and does no parity check. Even with force on, neither `err_flag` nor `err_irq` is raised.
- R6: Mode 2 (binary 10) returns the stored parity instead of the data. Bit i of `rsp_data` is the parity of byte i, and the upper bits are 0. No check is made.
- R7: Mode 3 (binary 11) checks parity and sets `err_flag` on an error, but never raises `err_irq`.
- R8: With `cfg_force`=1 every checked read is an error. With force 0 the generated contents never give an error.
- R9: A `cfg_we` pulse loads `cfg_mode` and `cfg_force` only while `cfg_lock`=0. While `cfg_lock`=1 the pulse leaves both unchanged.
- R10: `err_flag` stays set until an `err_clr` pulse. If an erroneous read is taken in the same cycle as the clear, the flag stays set.
- R11: `err_irq` lasts one cycle for each erroneous read taken, and falls in the next cycle unless that cycle also takes an erroneous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 8 | Word address of the request |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_data | output | 32 | Read word, or the parity bits in mode 2 |
| cfg_we | input | 1 | Load strobe for the mode and force controls |
| cfg_mode | input | 2 | New read mode |
| cfg_force | input | 1 | New force-error value |
| cfg_lock | input | 1 | Blocks the load strobe while 1 |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky parity error flag |
| err_irq | output | 1 | One-cycle pulse for each erroneous read |

## Verification
A table crosses all four modes with force on and off over a spread of addresses, including both ends of the address range. An error that reaches the interrupt, an error that only reaches the flag, and a read that bypasses the checker therefore each give a different pair of flag and interrupt results, and the parity view gives a different data value from a normal read. Directed sequences then check that the lock is honoured and that the flag stays sticky over later clean reads. They also cover a clear coinciding with a new error, and a response held under back-pressure while a second request waits.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    MODE_CHECK   = 2'b00,
    MODE_NOCHECK = 2'b01,
    MODE_SHOWPAR = 2'b10,
    MODE_QUIET   = 2'b11
  } rd_mode_e;

  localparam logic [31:0] HASH_MUL = 32'h9E37_79B1;
  localparam logic [31:0] HASH_XOR = 32'hC3A5_0F96;
endpackage

// File: rtl/rpg_store.sv
module rpg_store #(
  parameter int AW = 8,
  parameter int W  = 32,
  localparam int NB    = W / 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  word,
  output logic [NB-1:0] par
);
  function automatic logic [W-1:0] gen_word(input logic [AW-1:0] a);
    logic [31:0] h;
    logic [63:0] rep;
    h   = (32'(a) * rpg_pkg::HASH_MUL) ^ rpg_pkg::HASH_XOR;
    rep = {h, h};
    return rep[W-1:0];
  endfunction

  function automatic logic [NB-1:0] gen_par(input logic [W-1:0] d);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

  logic [W-1:0]  data_tbl [DEPTH];
  logic [NB-1:0] par_tbl  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign data_tbl[g] = gen_word(AW'(g));
    assign par_tbl[g]  = gen_par(gen_word(AW'(g)));
  end

  assign word = data_tbl[addr];
  assign par  = par_tbl[addr];
endmodule

// File: rtl/rpg_ctrl.sv
module rpg_ctrl
  import rpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_lock,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_force,
  output rd_mode_e   mode_q,
  output logic       force_q
);
  logic load;
  assign load = cfg_we && !cfg_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_CHECK;
      force_q <= 1'b0;
    end else if (load) begin
      mode_q  <= rd_mode_e'(cfg_mode);
      force_q <= cfg_force;
    end
  end
endmodule

// File: rtl/rpg_check.sv
module rpg_check #(
  parameter int W = 32,
  localparam int NB = W / 8
) (
  input  logic [W-1:0]  word,
  input  logic [NB-1:0] par,
  input  logic          force_inv,
  output logic          bad
);
  logic [NB-1:0] seen_par;
  logic [NB-1:0] byte_bad;

  assign seen_par = force_inv ? ~par : par;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign byte_bad[i] = ^{word[8*i +: 8], seen_par[i]};
  end

  assign bad = |byte_bad;
endmodule

// File: rtl/rom_parity_guard.sv
module rom_parity_guard
  import rpg_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [W-1:0]  rsp_data,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_force,
  input  logic          cfg_lock,
  input  logic          err_clr,
  output logic          err_flag,
  output logic          err_irq
);
  localparam int NB = W / 8;

  rd_mode_e      mode_q;
  logic          force_q;
  logic [W-1:0]  st_word;
  logic [NB-1:0] st_par;
  logic          par_bad;
  logic          take;
  logic          chk_on;
  logic          hit;
  logic [W-1:0]  out_word;

  rpg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_lock (cfg_lock),
    .cfg_mode (cfg_mode),
    .cfg_force(cfg_force),
    .mode_q   (mode_q),
    .force_q  (force_q)
  );

  rpg_store #(.AW(AW), .W(W)) u_store (
    .addr(req_addr),
    .word(st_word),
    .par (st_par)
  );

  rpg_check #(.W(W)) u_check (
    .word     (st_word),
    .par      (st_par),
    .force_inv(force_q),
    .bad      (par_bad)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign chk_on    = (mode_q == MODE_CHECK) || (mode_q == MODE_QUIET);
  assign hit       = take && chk_on && par_bad;
  assign out_word  = (mode_q == MODE_SHOWPAR) ? {{(W-NB){1'b0}}, st_par} : st_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      err_irq   <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (take) begin
        rsp_valid <= 1'b1;
        rsp_data  <= out_word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      err_irq <= hit && (mode_q == MODE_CHECK);
      if (hit)          err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rom_parity_guard_chk.sv
module rom_parity_guard_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_data,
  input logic         cfg_we,
  input logic         cfg_lock,
  input logic [1:0]   mode_q,
  input logic         force_q,
  input logic         err_clr,
  input logic         err_flag,
  input logic         err_irq
);
  // R2
  take_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R9
  lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(mode_q) && $stable(force_q));

  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> err_flag && rsp_valid);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  // R5
  nocheck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && mode_q == 2'b01 && !cfg_we |=> !err_irq);

  // R7
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b11 && !cfg_we |=> !err_irq);
endmodule

bind rom_parity_guard rom_parity_guard_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .cfg_we   (cfg_we),
  .cfg_lock (cfg_lock),
  .mode_q   (mode_q),
  .force_q  (force_q),
  .err_clr  (err_clr),
  .err_flag (err_flag),
  .err_irq  (err_irq)
);

// File: tb/sim_rom_parity_guard.sv
module sim_rom_parity_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_force = 1'b0;
  logic        cfg_lock = 1'b0;
  logic        err_clr = 1'b0;
  logic        err_flag;
  logic        err_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_parity_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_force(cfg_force), .cfg_lock(cfg_lock), .err_clr(err_clr),
    .err_flag(err_flag), .err_irq(err_irq)
  );

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hC3A50F96;
  endfunction

  function automatic logic [31:0] exp_par(input logic [7:0] a);
    logic [31:0] w = exp_word(a);
    return {28'b0, ^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic f);
    cfg_we = 1'b1; cfg_mode = m; cfg_force = f;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic clr);
    req_valid = 1'b1; req_addr = a; err_clr = clr;
    tick();
    req_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic clear_flag();
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0] mode;
    logic       frc;
    logic [7:0] addr;
    logic       e_err;
    logic       e_irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{2'b00, 1'b0, 8'h3C, 1'b0, 1'b0},
    '{2'b00, 1'b1, 8'h11, 1'b1, 1'b1},
    '{2'b01, 1'b1, 8'h22, 1'b0, 1'b0},
    '{2'b01, 1'b0, 8'h7F, 1'b0, 1'b0},
    '{2'b10, 1'b0, 8'h80, 1'b0, 1'b0},
    '{2'b10, 1'b1, 8'hFE, 1'b0, 1'b0},
    '{2'b11, 1'b1, 8'h45, 1'b1, 1'b0},
    '{2'b11, 1'b0, 8'h99, 1'b0, 1'b0},
    '{2'b00, 1'b1, 8'hFF, 1'b1, 1'b1}
  };

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] ew;
    #(CLK_PERIOD*2 + 3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!rsp_valid, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(!err_flag,  "R1 err_flag",  32'(err_flag), 0);
    chk(!err_irq,   "R1 err_irq",   32'(err_irq), 0);
    chk(req_ready,  "R1 req_ready", 32'(req_ready), 1);
    rd(8'h05, 1'b0);
    chk(rsp_valid && rsp_data == exp_word(8'h05), "R1 default read", rsp_data, exp_word(8'h05));
    chk(!err_flag && !err_irq, "R1 no error by default", {err_flag, err_irq}, 0);
    tick();

    // table walk: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i].mode, VEC[i].frc);
      clear_flag();
      rd(VEC[i].addr, 1'b0);
      ew = (VEC[i].mode == 2'b10) ? exp_par(VEC[i].addr) : exp_word(VEC[i].addr);
      chk(rsp_valid && rsp_data == ew, $sformatf("R2/R6 data vec%0d", i), rsp_data, ew);
      chk(err_flag == VEC[i].e_err, $sformatf("R4/R5/R7/R8 flag vec%0d", i), 32'(err_flag), 32'(VEC[i].e_err));
      chk(err_irq == VEC[i].e_irq, $sformatf("R4/R7 irq vec%0d", i), 32'(err_irq), 32'(VEC[i].e_irq));
      tick();
      // R11 pulse falls with no new request
      chk(!err_irq, $sformatf("R11 irq low after vec%0d", i), 32'(err_irq), 0);
    end

    // R9 lock blocks updates
    set_cfg(2'b11, 1'b1);
    cfg_lock = 1'b1;
    set_cfg(2'b10, 1'b0);
    cfg_lock = 1'b0;
    clear_flag();
    rd(8'h33, 1'b0);
    chk(rsp_data == exp_word(8'h33), "R9 locked mode kept", rsp_data, exp_word(8'h33));
    chk(err_flag && !err_irq, "R9 locked force kept", {err_flag, err_irq}, 32'b10);
    tick();

    // R10 sticky flag, clear, set beats clear
    set_cfg(2'b00, 1'b0);
    rd(8'h34, 1'b0);
    chk(err_flag, "R10 flag sticky over clean read", 32'(err_flag), 1);
    chk(!err_irq, "R8 clean read no irq", 32'(err_irq), 0);
    clear_flag();
    chk(!err_flag, "R10 flag cleared", 32'(err_flag), 0);
    set_cfg(2'b00, 1'b1);
    rd(8'h35, 1'b1);
    chk(err_flag && err_irq, "R10 set beats clear", {err_flag, err_irq}, 32'b11);
    // R11 back-to-back errors each pulse
    rd(8'h36, 1'b0);
    chk(err_irq, "R11 second erroneous read pulses", 32'(err_irq), 1);
    tick();
    chk(!err_irq, "R11 irq falls", 32'(err_irq), 0);
    set_cfg(2'b00, 1'b0);
    clear_flag();

    // R3 back-pressure
    rsp_ready = 1'b0;
    rd(8'h10, 1'b0);
    chk(rsp_valid && !req_ready, "R3 ready drops while held", {rsp_valid, req_ready}, 32'b10);
    req_valid = 1'b1; req_addr = 8'h20;
    tick();
    tick();
    chk(rsp_data == exp_word(8'h10), "R3 data held", rsp_data, exp_word(8'h10));
    chk(!req_ready, "R3 request waits", 32'(req_ready), 0);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready, "R3 ready with consumer", 32'(req_ready), 1);
    tick();
    req_valid = 1'b0;
    chk(rsp_valid && rsp_data == exp_word(8'h20), "R3 waiting request served", rsp_data, exp_word(8'h20));
    tick();
    chk(!rsp_valid, "R2 response consumed", 32'(rsp_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule